// File: doc/BRIEF.md
# SDRAM Special-Mode Command Override

This block sits between a host memory-cycle request port and an SDRAM command bus. It holds an 8-bit control register that software writes to pick a refresh policy and a special mode. While a special mode is selected, every host cycle aimed at DRAM is acknowledged at once and replaced by one fixed SDRAM command. The fixed command is one of NOP, precharge of all banks, mode-register load or auto (CBR) refresh. These modes are used to bring the memory up after power-on and to test it. In normal mode the host cycle is handed to a downstream access path through a request/acknowledge pair, and the command bus is left alone.

A periodic refresh generator is built in and gated by the refresh field of the register. When an interval expires it takes the command slot for one cycle and issues an auto-refresh. A host cycle presented in that cycle waits. The initialisation order requires NOP to be selected before any other special command. A sticky flag reports a host cycle that was converted while that order had not yet been met, and that cycle emits only a NOP.

Top module: `sdram_special_cmd`

## Requirements
- R1: After reset the register reads 08h, the bus drives deselect and `seq_err` is low.
- R2: All eight register bits read back exactly as last written, including the unused bits 7:5 and reserved field codes. Bits 4:3 are the refresh field and bits 2:0 are the mode field.
- R3: Mode code 001 (NOP): a host request is acknowledged in the cycle it is presented. In the next cycle the bus carries CS#,RAS#,CAS#,WE# = 0,1,1,1 with MA = 0, for one cycle only.
- R4: Mode code 010 (precharge all): as R3, with the bus carrying 0,0,1,0 and MA = 400h (only MA[10] set).
- R5: Mode code 011 (mode-register load): as R3, with the bus carrying 0,0,0,0. MA[6:0] equals `host_addr[6:0]` (burst length in 2:0, wrap type in 3, latency in 6:4) and MA[11:7] is always zero.
- R6: Mode code 100 (CBR refresh): as R3, with the bus carrying 0,0,0,1 and MA = 0.
- R7: Mode code 000 (normal): the host request appears on `norm_req`, `host_ack` follows `norm_ack`, and the bus stays deselected.
- R8: Mode codes 101, 110 and 111 behave as normal mode. Refresh codes 10 and 11 behave as refresh disabled.
- R9: If NOP (a write with mode code 001) has not been written since reset, a host cycle in precharge, mode-load or CBR mode is acknowledged but drives a NOP. It also sets `seq_err`, which stays set until reset.
- R10: With refresh code 01, an auto-refresh (0,0,0,1, MA = 0) is driven on the bus every REF_INTERVAL cycles. In the cycle the refresh takes the slot, no host request is acknowledged and `norm_req` is low.
- R11: With refresh disabled the interval counter is held at zero and no automatic refresh is issued. On re-enabling, the first refresh comes a full interval later.
- R12: With no host request and no refresh due, the bus drives 1,1,1,1 with MA = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write value |
| cfg_rd_data | output | 8 | Register contents |
| host_req | input | 1 | Host DRAM cycle request |
| host_addr | input | 7 | Host address bits that feed the mode-load fields |
| host_ack | output | 1 | Host cycle accepted this cycle |
| norm_req | output | 1 | Request forwarded to the normal access path |
| norm_ack | input | 1 | Acceptance from the normal access path |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ma | output | 12 | SDRAM address lines |
| seq_err | output | 1 | Sticky flag: special command requested before NOP was written |

## Verification
The hardest situation to reach is a refresh slot that lands exactly on a cycle with a host request pending in a special mode. Reaching it needs the refresh counter phase to line up with host traffic. The stimulus holds `host_req` high without a break for several whole intervals in NOP mode, so that every interval boundary collides with a request, and the per-clock model expects the missing acknowledge there. The ordering rule is exercised by selecting mode-load and precharge right after reset, before any NOP write, and then again after one.

// File: rtl/sdram_ovr_pkg.sv
package sdram_ovr_pkg;

    localparam int MA_W  = 12;
    localparam int MRS_W = 7;

    localparam logic [7:0] CTRL_RESET = 8'h08;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CTL_DESEL = 4'b1111;
    localparam logic [3:0] CTL_NOP   = 4'b0111;
    localparam logic [3:0] CTL_PALL  = 4'b0010;
    localparam logic [3:0] CTL_MRS   = 4'b0000;
    localparam logic [3:0] CTL_CBR   = 4'b0001;

    localparam logic [MA_W-1:0] MA_ALLBANK = MA_W'(1) << 10;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'b000,
        MODE_NOP    = 3'b001,
        MODE_PALL   = 3'b010,
        MODE_MRS    = 3'b011,
        MODE_CBR    = 3'b100
    } spec_mode_e;

    typedef struct packed {
        logic            cs_n;
        logic            ras_n;
        logic            cas_n;
        logic            we_n;
        logic [MA_W-1:0] ma;
    } sdram_cmd_t;

    function automatic spec_mode_e decode_mode(input logic [2:0] f);
        case (f)
            3'b001:  return MODE_NOP;
            3'b010:  return MODE_PALL;
            3'b011:  return MODE_MRS;
            3'b100:  return MODE_CBR;
            default: return MODE_NORMAL;
        endcase
    endfunction

    function automatic logic decode_refresh(input logic [1:0] f);
        return (f == 2'b01);
    endfunction

    function automatic sdram_cmd_t mk_cmd(input logic [3:0] ctl, input logic [MA_W-1:0] ma);
        return {ctl, ma};
    endfunction

endpackage

// File: rtl/sdram_ovr_ctrl_reg.sv
module sdram_ovr_ctrl_reg
    import sdram_ovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output spec_mode_e mode_o,
    output logic       ref_en_o,
    output logic       nop_seen_o
);
    logic [7:0] ctrl_q;
    logic       nop_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RESET;
            nop_seen_q <= 1'b0;
        end else if (wr_en) begin
            ctrl_q     <= wr_data;
            nop_seen_q <= nop_seen_q | (wr_data[2:0] == MODE_NOP);
        end
    end

    always_comb begin
        rd_data    = ctrl_q;
        mode_o     = decode_mode(ctrl_q[2:0]);
        ref_en_o   = decode_refresh(ctrl_q[4:3]);
        nop_seen_o = nop_seen_q;
    end
endmodule

// File: rtl/sdram_ovr_refresh.sv
module sdram_ovr_refresh #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    output logic grant_o
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             due_q;

    always_ff @(posedge clk) begin
        if (rst || !ref_en) begin
            cnt_q <= '0;
            due_q <= 1'b0;
        end else begin
            due_q <= (cnt_q == LAST);
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // due_q is a one-cycle pulse and always takes the slot it is raised for
    assign grant_o = due_q & ref_en;
endmodule

// File: rtl/sdram_ovr_issue.sv
module sdram_ovr_issue
    import sdram_ovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  spec_mode_e       mode,
    input  logic             nop_seen,
    input  logic             ref_grant,
    input  logic             host_req,
    input  logic [MRS_W-1:0] host_addr,
    input  logic             norm_ack,
    output logic             host_ack,
    output logic             norm_req,
    output sdram_cmd_t       cmd_o,
    output logic             seq_err_o
);
    logic       special;
    logic       host_take;
    logic       blocked;
    sdram_cmd_t cmd_d;
    sdram_cmd_t cmd_q;
    logic       err_q;

    always_comb begin
        special   = (mode != MODE_NORMAL);
        host_take = host_req & special & ~ref_grant;
        blocked   = special & (mode != MODE_NOP) & ~nop_seen;
        host_ack  = host_req & ~ref_grant & (special | norm_ack);
        norm_req  = host_req & ~special & ~ref_grant;

        cmd_d = mk_cmd(CTL_DESEL, '0);
        if (ref_grant) begin
            cmd_d = mk_cmd(CTL_CBR, '0);
        end else if (host_take) begin
            if (blocked) begin
                cmd_d = mk_cmd(CTL_NOP, '0);
            end else begin
                case (mode)
                    MODE_NOP:  cmd_d = mk_cmd(CTL_NOP, '0);
                    MODE_PALL: cmd_d = mk_cmd(CTL_PALL, MA_ALLBANK);
                    MODE_MRS:  cmd_d = mk_cmd(CTL_MRS, {{(MA_W-MRS_W){1'b0}}, host_addr});
                    MODE_CBR:  cmd_d = mk_cmd(CTL_CBR, '0);
                    default:   cmd_d = mk_cmd(CTL_DESEL, '0);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= mk_cmd(CTL_DESEL, '0);
            err_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            err_q <= err_q | (host_take & blocked);
        end
    end

    assign cmd_o     = cmd_q;
    assign seq_err_o = err_q;
endmodule

// File: rtl/sdram_special_cmd.sv
module sdram_special_cmd
    import sdram_ovr_pkg::*;
#(
    parameter int REF_INTERVAL = 1560
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       cfg_rd_data,
    input  logic             host_req,
    input  logic [MRS_W-1:0] host_addr,
    output logic             host_ack,
    output logic             norm_req,
    input  logic             norm_ack,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [MA_W-1:0]  sd_ma,
    output logic             seq_err
);
    spec_mode_e mode;
    logic       ref_en;
    logic       nop_seen;
    logic       ref_grant;
    sdram_cmd_t bus;

    sdram_ovr_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .rd_data    (cfg_rd_data),
        .mode_o     (mode),
        .ref_en_o   (ref_en),
        .nop_seen_o (nop_seen)
    );

    sdram_ovr_refresh #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .ref_en  (ref_en),
        .grant_o (ref_grant)
    );

    sdram_ovr_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .nop_seen  (nop_seen),
        .ref_grant (ref_grant),
        .host_req  (host_req),
        .host_addr (host_addr),
        .norm_ack  (norm_ack),
        .host_ack  (host_ack),
        .norm_req  (norm_req),
        .cmd_o     (bus),
        .seq_err_o (seq_err)
    );

    assign sd_cs_n  = bus.cs_n;
    assign sd_ras_n = bus.ras_n;
    assign sd_cas_n = bus.cas_n;
    assign sd_we_n  = bus.we_n;
    assign sd_ma    = bus.ma;
endmodule

// File: rtl/sdram_special_cmd_chk.sv
module sdram_special_cmd_chk
    import sdram_ovr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_req,
    input logic             host_ack,
    input spec_mode_e       mode,
    input logic             ref_en,
    input logic             ref_grant,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [MA_W-1:0]  sd_ma,
    input logic             seq_err
);
    logic [3:0] ctl;
    assign ctl = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> host_req);

    assert_special_emits_R3: assert property (@(posedge clk) disable iff (rst)
        (host_ack && mode != MODE_NORMAL) |=> !sd_cs_n);

    assert_normal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (host_req && mode == MODE_NORMAL && !ref_grant) |=> sd_cs_n);

    assert_mrs_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl == CTL_MRS) |-> (sd_ma[MA_W-1:MRS_W] == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    assert_refresh_stalls_R10: assert property (@(posedge clk) disable iff (rst)
        ref_grant |-> !host_ack);

    assert_refresh_cbr_R10: assert property (@(posedge clk) disable iff (rst)
        ref_grant |=> (ctl == CTL_CBR));

    assert_no_auto_ref_off_R11: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && !host_req) |=> (ctl != CTL_CBR));

    assert_idle_deselect_R12: assert property (@(posedge clk) disable iff (rst)
        (!host_req && !ref_grant) |=> (ctl == CTL_DESEL && sd_ma == '0));
endmodule

bind sdram_special_cmd sdram_special_cmd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_ack  (host_ack),
    .mode      (mode),
    .ref_en    (ref_en),
    .ref_grant (ref_grant),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ma     (sd_ma),
    .seq_err   (seq_err)
);

// File: tb/test_sdram_special_cmd.sv
`timescale 1ns/1ps
module test_sdram_special_cmd;
    localparam int INT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        host_req = 1'b0;
    logic [6:0]  host_addr = '0;
    logic        host_ack;
    logic        norm_req;
    logic        norm_ack = 1'b1;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_ma;
    logic        seq_err;

    always #2.5 clk = ~clk;

    sdram_special_cmd #(.REF_INTERVAL(INT)) i_sdram_special_cmd (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .host_req(host_req), .host_addr(host_addr),
        .host_ack(host_ack), .norm_req(norm_req), .norm_ack(norm_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ma(sd_ma), .seq_err(seq_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cbr_seen = 0;
    string phase = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0]  m_reg;
    bit          m_nop, m_err, m_pend;
    int          m_cnt;
    logic [3:0]  m_ctl;
    logic [11:0] m_ma;

    always @(negedge clk) begin
        bit refen, grant, special, take, blocked, exp_ack, exp_nreq;
        int md;
        if (rst) begin
            m_reg = 8'h08; m_nop = 0; m_err = 0; m_pend = 0; m_cnt = 0;
            m_ctl = 4'b1111; m_ma = '0;
        end else begin
            refen    = (m_reg[4:3] == 2'b01);
            md       = (m_reg[2:0] <= 3'd4) ? int'(m_reg[2:0]) : 0;
            grant    = m_pend && refen;
            special  = (md != 0);
            take     = host_req && special && !grant;
            blocked  = special && md != 1 && !m_nop;
            exp_ack  = host_req && !grant && (special || norm_ack);
            exp_nreq = host_req && !special && !grant;

            chk(cfg_rd_data == m_reg, phase, "reg", cfg_rd_data, m_reg);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == m_ctl, phase, "ctl",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, m_ctl);
            chk(sd_ma == m_ma, phase, "ma", sd_ma, m_ma);
            chk(host_ack == exp_ack, phase, "host_ack", host_ack, exp_ack);
            chk(norm_req == exp_nreq, phase, "norm_req", norm_req, exp_nreq);
            chk(seq_err == m_err, phase, "seq_err", seq_err, m_err);
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) cbr_seen++;

            // next state
            m_ctl = 4'b1111; m_ma = '0;
            if (grant) m_ctl = 4'b0001;
            else if (take) begin
                if (blocked) m_ctl = 4'b0111;
                else if (md == 1) m_ctl = 4'b0111;
                else if (md == 2) begin m_ctl = 4'b0010; m_ma = 12'h400; end
                else if (md == 3) begin m_ctl = 4'b0000; m_ma = {5'b0, host_addr}; end
                else m_ctl = 4'b0001;
            end
            if (take && blocked) m_err = 1;
            if (!refen) begin m_cnt = 0; m_pend = 0; end
            else begin
                m_pend = (m_cnt == INT - 1);
                m_cnt  = m_pend ? 0 : m_cnt + 1;
            end
            if (cfg_wr_en) begin
                m_reg = cfg_wr_data;
                if (cfg_wr_data[2:0] == 3'b001) m_nop = 1;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        step(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic host_cycle(input logic [6:0] a);
        host_req = 1'b1; host_addr = a;
        @(negedge clk);
        while (!host_ack) @(negedge clk);
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic host_hold(input int n, input logic [6:0] a);
        host_req = 1'b1; host_addr = a;
        step(n);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_rd_data == 8'h08, "R1", "reset reg", cfg_rd_data, 8'h08);
        chk(sd_cs_n == 1'b1, "R1", "reset cs_n", sd_cs_n, 1);
        chk(seq_err == 1'b0, "R1", "reset seq_err", seq_err, 0);
        step(1);

        // R9: mode-load and precharge before any NOP write
        phase = "R9";
        wr_cfg(8'h0B);
        host_cycle(7'h35);
        step(1);
        wr_cfg(8'h0A);
        host_cycle(7'h00);
        step(1);
        @(negedge clk);
        chk(seq_err == 1'b1, "R9", "seq_err sticky", seq_err, 1);
        step(1);

        // R7: normal path, both ack polarities
        phase = "R7";
        wr_cfg(8'h08);
        norm_ack = 1'b0;
        host_hold(3, 7'h11);
        norm_ack = 1'b1;
        host_cycle(7'h22);
        step(2);

        phase = "R3";
        wr_cfg(8'h09);
        host_cycle(7'h7F);
        host_cycle(7'h01);
        step(2);

        phase = "R5";
        wr_cfg(8'h0B);
        host_cycle(7'h7F);
        host_cycle(7'h32);
        host_cycle(7'h00);
        host_cycle(7'h4A);
        step(2);

        phase = "R4";
        wr_cfg(8'h0A);
        host_cycle(7'h55);
        step(2);

        phase = "R6";
        wr_cfg(8'h0C);
        host_cycle(7'h12);
        host_cycle(7'h13);
        step(2);

        // R2 / R8: reserved codes stored, behave as normal + refresh off
        phase = "R8";
        wr_cfg(8'hFF);
        @(negedge clk);
        chk(cfg_rd_data == 8'hFF, "R2", "readback FF", cfg_rd_data, 8'hFF);
        step(2);
        cbr_seen = 0;
        host_cycle(7'h0F);
        step(2 * INT);
        chk(cbr_seen == 0, "R8", "cbr under reserved refresh code", cbr_seen, 0);
        wr_cfg(8'h15);
        @(negedge clk);
        chk(cfg_rd_data == 8'h15, "R2", "readback 15", cfg_rd_data, 8'h15);
        host_cycle(7'h44);
        step(2);
        wr_cfg(8'hE6);
        @(negedge clk);
        chk(cfg_rd_data == 8'hE6, "R2", "readback E6", cfg_rd_data, 8'hE6);
        host_cycle(7'h2B);
        step(2);

        // R11: refresh off
        phase = "R11";
        wr_cfg(8'h01);
        step(2);
        cbr_seen = 0;
        step(3 * INT);
        chk(cbr_seen == 0, "R11", "cbr while disabled", cbr_seen, 0);

        // R10: re-enable, idle, then collide with held requests
        phase = "R10";
        wr_cfg(8'h08);
        cbr_seen = 0;
        step(3 * INT);
        chk(cbr_seen >= 2 && cbr_seen <= 3, "R10", "cbr count idle", cbr_seen, 3);
        wr_cfg(8'h09);
        cbr_seen = 0;
        host_hold(3 * INT, 7'h05);
        step(2);
        chk(cbr_seen >= 2, "R10", "cbr count under load", cbr_seen, 3);

        phase = "R12";
        step(INT / 2);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule